// File: doc/BRIEF.md
# Issue-stage stack pointer offset tracker

This block sits in the issue stage of an out-of-order core, ahead of rename. It takes over the fixed stack pointer adjustments made by push, pop, call and return. It does this with a small signed displacement register that holds the distance from the committed stack pointer. The execution core then only sees the memory half of each stack operation. That half is a load or store micro-op whose address is the stack pointer plus a displacement supplied by this block. No arithmetic micro-op is needed for the adjustment itself.

Two events force the real stack pointer register to catch up:

- an adjustment that would carry the displacement outside its signed range;
- an instruction that reads the stack pointer value directly while a displacement is pending.

In either case the block emits a synchronisation micro-op, which carries the pending displacement as an immediate. It holds the incoming instruction back for one cycle and zeroes the displacement. The held instruction then issues in the next cycle against a displacement of zero. A flush input zeroes the displacement because the recovery path restores the stack pointer.

Top module: `stk_offset_tracker`

## Requirements
- R1: After reset the displacement is zero, `in_ready` is 1 and `out_valid` is 0. A first push therefore issues with displacement -STEP.
- R2: A push (`in_op`=1) or call (`in_op`=3) that fits issues one store micro-op (`out_kind`=2). Its `out_imm` is the displacement minus STEP, and the displacement becomes that value.
- R3: A pop (`in_op`=2) or return (`in_op`=4) that fits issues exactly one load micro-op (`out_kind`=1). Its `out_imm` is the current displacement, and the displacement then rises by STEP.
- R4: If a push, call, pop or return would move the displacement outside [-2^(DISP_W-1), 2^(DISP_W-1)-1], the block does the following in that cycle:
  - it issues a sync micro-op (`out_kind`=3) with `out_imm` equal to the displacement;
  - it drives `in_ready` low;
  - it zeroes the displacement.
  The held instruction then issues in the next cycle, based on zero.
- R5: A direct stack pointer reader (`in_op`=5) is handled by the current displacement:
  - with a non-zero displacement, it first causes a sync micro-op as in R4;
  - with a zero displacement, it issues at once as passthrough (`out_kind`=0, `out_imm`=0).
- R6: Any other opcode (0, 6, 7) issues as passthrough with `out_imm`=0 and leaves the displacement unchanged.
- R7: While `flush` is 1, `out_valid` and `in_ready` are 0. The displacement is zero afterwards.
- R8: While `in_valid` is 0 and `flush` is 0, `out_valid` is 0, `in_ready` is 1 and the displacement is unchanged.
- R9: Every valid output micro-op carries the `in_tag` of the instruction presented in that cycle, including sync micro-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush, clears the displacement |
| in_valid | input | 1 | Instruction presented |
| in_op | input | 3 | Stack class of the instruction (encodings in R2 to R6) |
| in_tag | input | TAG_W | Instruction identifier |
| in_ready | output | 1 | Instruction accepted this cycle |
| out_valid | output | 1 | Micro-op issued this cycle |
| out_kind | output | 2 | 0 passthrough, 1 load, 2 store, 3 sync |
| out_imm | output | DISP_W | Signed address displacement, or sync immediate |
| out_tag | output | TAG_W | Tag of the originating instruction |

## Verification
The bench builds the block with DISP_W=6 and STEP=4. The range is then -32 to 31, so eight pushes from zero reach the lower edge and seven pops reach 28, one step short of the upper edge. Overflow syncs in both directions therefore occur often under random push/pop drift, not only in directed runs. Flushes and direct reads land at many different displacements, including zero.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_SPUSE = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {
    K_PASS  = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_SYNC  = 2'd3
  } uop_kind_e;

  // Signed range limits of a DISP_W-bit displacement, held as 32-bit values.
  function automatic logic signed [31:0] disp_min(input int w);
    return -(32'sd1 <<< (w - 1));
  endfunction

  function automatic logic signed [31:0] disp_max(input int w);
    return (32'sd1 <<< (w - 1)) - 32'sd1;
  endfunction

  function automatic logic in_range(input logic signed [31:0] v, input int w);
    return (v >= disp_min(w)) && (v <= disp_max(w));
  endfunction

endpackage

// File: rtl/stk_classify.sv
module stk_classify (
  input  logic [2:0] op,
  output logic       is_dec,
  output logic       is_inc,
  output logic       is_use
);
  import stk_pkg::*;

  always_comb begin
    is_dec = 1'b0;
    is_inc = 1'b0;
    is_use = 1'b0;
    case (op)
      OP_PUSH, OP_CALL: is_dec = 1'b1;
      OP_POP, OP_RET:   is_inc = 1'b1;
      OP_SPUSE:         is_use = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_delta_reg.sv
module stk_delta_reg #(
  parameter int DISP_W = 8,
  parameter int STEP   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     do_dec,
  input  logic                     do_inc,
  output logic signed [DISP_W-1:0] disp,
  output logic signed [DISP_W-1:0] disp_dec,
  output logic                     dec_ovf,
  output logic                     inc_ovf,
  output logic                     nonzero
);
  import stk_pkg::*;

  logic signed [31:0] cur_w, dec_w, inc_w;

  assign cur_w    = 32'(disp);
  assign dec_w    = cur_w - 32'(STEP);
  assign inc_w    = cur_w + 32'(STEP);
  assign dec_ovf  = !in_range(dec_w, DISP_W);
  assign inc_ovf  = !in_range(inc_w, DISP_W);
  assign nonzero  = (disp != '0);
  assign disp_dec = dec_w[DISP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) disp <= '0;
    else if (do_dec)   disp <= dec_w[DISP_W-1:0];
    else if (do_inc)   disp <= inc_w[DISP_W-1:0];
  end

  a_r2_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (do_dec && !clr) |=> (32'(disp) == $past(cur_w) - 32'(STEP)));
  a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (do_inc && !clr) |=> (32'(disp) == $past(cur_w) + 32'(STEP)));
  a_r4_no_wrap_dec: assert property (@(posedge clk) disable iff (!rst_n)
    do_dec |-> !dec_ovf);
  a_r4_no_wrap_inc: assert property (@(posedge clk) disable iff (!rst_n)
    do_inc |-> !inc_ovf);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (disp == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !do_dec && !do_inc) |=> $stable(disp));
endmodule

// File: rtl/stk_issue_mux.sv
module stk_issue_mux #(
  parameter int DISP_W = 8
) (
  input  logic                     sync_fire,
  input  logic                     issue_dec,
  input  logic                     issue_inc,
  input  logic signed [DISP_W-1:0] disp,
  input  logic signed [DISP_W-1:0] disp_dec,
  output logic [1:0]               kind,
  output logic signed [DISP_W-1:0] imm
);
  import stk_pkg::*;

  always_comb begin
    kind = K_PASS;
    imm  = '0;
    if (sync_fire) begin
      kind = K_SYNC;
      imm  = disp;
    end else if (issue_dec) begin
      kind = K_STORE;
      imm  = disp_dec;
    end else if (issue_inc) begin
      kind = K_LOAD;
      imm  = disp;
    end
  end
endmodule

// File: rtl/stk_offset_tracker.sv
module stk_offset_tracker #(
  parameter int DISP_W = 8,
  parameter int STEP   = 8,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              in_ready,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [DISP_W-1:0] out_imm,
  output logic [TAG_W-1:0]  out_tag
);
  import stk_pkg::*;

  localparam int SPAN = 1 << (DISP_W - 1);

  initial begin
    if (STEP <= 0 || STEP >= SPAN)
      $error("STEP must lie strictly between 0 and the displacement span");
  end

  logic is_dec, is_inc, is_use;
  logic signed [DISP_W-1:0] disp, disp_dec, imm_s;
  logic dec_ovf, inc_ovf, nonzero;
  logic live, need_sync, sync_fire, issue_dec, issue_inc;

  stk_classify u_cls (
    .op(in_op), .is_dec(is_dec), .is_inc(is_inc), .is_use(is_use)
  );

  // Named events of the issue decision.
  assign live      = in_valid && !flush;
  assign need_sync = (is_dec && dec_ovf) || (is_inc && inc_ovf) || (is_use && nonzero);
  assign sync_fire = live && need_sync;
  assign issue_dec = live && !need_sync && is_dec;
  assign issue_inc = live && !need_sync && is_inc;

  stk_delta_reg #(.DISP_W(DISP_W), .STEP(STEP)) u_delta (
    .clk(clk), .rst_n(rst_n), .clr(flush || sync_fire),
    .do_dec(issue_dec), .do_inc(issue_inc),
    .disp(disp), .disp_dec(disp_dec),
    .dec_ovf(dec_ovf), .inc_ovf(inc_ovf), .nonzero(nonzero)
  );

  stk_issue_mux #(.DISP_W(DISP_W)) u_mux (
    .sync_fire(sync_fire), .issue_dec(issue_dec), .issue_inc(issue_inc),
    .disp(disp), .disp_dec(disp_dec), .kind(out_kind), .imm(imm_s)
  );

  assign out_imm   = imm_s;
  assign out_valid = live;
  assign out_tag   = in_tag;
  assign in_ready  = !flush && !sync_fire;

  a_r4_sync_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd3) |-> !in_ready);
  a_r4_sync_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd3) |=> (disp == '0));
  a_r5_use_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_ready && is_use) |-> (disp == '0 && out_kind == 2'd0));
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && !in_ready));
  a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flush) |-> (in_ready && !out_valid));
  a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_ready && is_inc) |-> (out_kind == 2'd1));
endmodule

// File: tb/sim_stk_offset_tracker.sv
module sim_stk_offset_tracker;
  localparam int W = 6;
  localparam int S = 4;
  localparam int TW = 6;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_op = '0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready, out_valid;
  logic [1:0] out_kind;
  logic [W-1:0] out_imm;
  logic [TW-1:0] out_tag;

  int checks = 0;
  int fails = 0;
  int md = 0;
  logic last_ready;

  always #5 clk = ~clk;

  stk_offset_tracker #(.DISP_W(W), .STEP(S), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_op(in_op), .in_tag(in_tag), .in_ready(in_ready),
    .out_valid(out_valid), .out_kind(out_kind), .out_imm(out_imm),
    .out_tag(out_tag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_dec(input logic [2:0] op);
    return op == 3'd1 || op == 3'd3;
  endfunction
  function automatic bit is_inc(input logic [2:0] op);
    return op == 3'd2 || op == 3'd4;
  endfunction

  // One cycle: drive on the falling edge, compare before the rising edge.
  task automatic cyc(input bit f, input bit v, input logic [2:0] op, input logic [TW-1:0] tag);
    int ek, ei, act_i;
    bit er, ns;
    string rq;
    @(negedge clk);
    flush = f; in_valid = v; in_op = op; in_tag = tag;
    #2;
    act_i = int'($signed(out_imm));
    last_ready = in_ready;
    if (f) begin
      check(!out_valid, "R7", out_valid, 0);
      check(!in_ready, "R7", in_ready, 0);
      md = 0;
    end else if (!v) begin
      check(!out_valid, "R8", out_valid, 0);
      check(in_ready, "R8", in_ready, 1);
    end else begin
      ns = (is_dec(op) && md - S < LO) || (is_inc(op) && md + S > HI) ||
           (op == 3'd5 && md != 0);
      if (ns) begin
        rq = (op == 3'd5) ? "R5" : "R4";
        ek = 3; ei = md; er = 0; md = 0;
      end else if (is_dec(op)) begin
        rq = "R2"; ek = 2; ei = md - S; er = 1; md = md - S;
      end else if (is_inc(op)) begin
        rq = "R3"; ek = 1; ei = md; er = 1; md = md + S;
      end else begin
        rq = (op == 3'd5) ? "R5" : "R6"; ek = 0; ei = 0; er = 1;
      end
      check(out_valid, rq, out_valid, 1);
      check(in_ready == er, rq, in_ready, er);
      check(out_kind == ek[1:0], rq, out_kind, ek);
      check(act_i == ei, rq, act_i, ei);
      check(out_tag == tag, "R9", out_tag, tag);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [TW-1:0] tag);
    int n = 0;
    do begin
      cyc(0, 1, op, tag);
      n++;
    end while (!last_ready && n < 4);
    check(last_ready, "R4", n, 2);
  endtask

  initial begin
    #300000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    int r, t;
    logic [2:0] op;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(!out_valid, "R1", out_valid, 0);
    check(in_ready, "R1", in_ready, 1);
    // R1: first push after reset stores at -STEP
    issue(3'd1, 6'd1);
    check(md == -S, "R1", md, -S);

    // R4: drive to the lower edge, the overflowing push syncs with LO
    for (int i = 0; i < 9; i++) issue(3'd3, TW'(i));
    // R5: direct reader with non-zero displacement syncs, zero passes
    issue(3'd5, 6'd20);
    issue(3'd5, 6'd21);
    // R7: flush with pending displacement then pop from zero
    issue(3'd1, 6'd22);
    cyc(1, 1, 3'd1, 6'd23);
    issue(3'd2, 6'd24);
    // R4: upper edge via pops
    cyc(1, 0, 3'd0, 6'd0);
    for (int i = 0; i < 9; i++) issue(3'd4, TW'(30 + i));
    // R6: plain opcodes leave displacement alone
    issue(3'd0, 6'd40); issue(3'd6, 6'd41); issue(3'd7, 6'd42);
    issue(3'd2, 6'd43);

    // Random stimulus with drifting bias.
    for (int i = 0; i < 3000; i++) begin
      r = $urandom % 100;
      t = $urandom % 10;
      if (r < 3) cyc(1, $urandom % 2, 3'($urandom % 8), TW'($urandom));
      else if (r < 15) cyc(0, 0, 3'($urandom % 8), TW'($urandom));
      else begin
        if (t < 4) op = ((i / 200) % 2 == 0) ? 3'd1 : 3'd2;
        else if (t < 6) op = 3'($urandom % 2 ? 3 : 4);
        else if (t < 7) op = 3'd5;
        else op = 3'($urandom % 8);
        issue(op, TW'($urandom));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule